// File: doc/BRIEF.md
# Attribute Table Entry Read Responder

This block answers read-entry requests for a device attribute table carried over a data-object mailbox. Upstream logic has already decoded an incoming request into its object length (in dwords) and a 16-bit entry handle. The responder checks both, looks up the entry's byte offset and byte length in an index RAM, and then writes the response into a dword-wide read mailbox. The response is a three-dword header followed by the entry's bytes.

The header tells host software which entry to ask for next. The next handle is the requested handle plus one, or the end marker 0xFFFF when the requested entry is the last stored one. Host software can therefore walk the whole table by starting at handle 0 and following the chain. The entry bytes are fetched from a byte-wide data RAM one byte per cycle, assembled into little-endian dwords and written behind the header.

Top module: `table_read_responder`

## Requirements
- R1: A request whose object length is less than 3 dwords is discarded. It produces no mailbox write, `busy` stays low and `bad_handle` stays low.
- R2: A request whose handle is greater than or equal to `entry_count` is discarded with no mailbox write. `bad_handle` pulses high for exactly the one cycle after the accepting edge.
- R3: Mailbox dword 0 of every response is 0x00021E98: vendor ID 0x1E98 in bits [15:0], object type 2 in bits [23:16], and zero in bits [31:24].
- R4: Mailbox dword 1 holds the response length in dwords, 3 + ceil(L/4) for an entry of L bytes, in bits [17:0]. Bits [31:18] are zero.
- R5: Mailbox dword 2 has response code 0 in bits [7:0] and table type 0 in bits [15:8]. Bits [31:16] hold the next handle: the requested handle plus one, or 0xFFFF when the requested handle equals `entry_count` - 1.
- R6: Entry byte i, read from data RAM address offset + i, lands in mailbox dword 3 + i/4 at bits [8*(i%4)+7 : 8*(i%4)]. The mailbox addresses of one response are written in ascending order with no gaps.
- R7: Byte lanes beyond the end of the entry in the final dword are zero.
- R8: `busy` rises on the cycle after a request is accepted and stays high through the cycle of the last mailbox write. Requests that arrive while `busy` is high are ignored. After reset, `busy`, `mbox_we` and `bad_handle` are low.
- R9: An entry of length 0 yields exactly the three header dwords.
- R10: The index RAM is read once per accepted request, at the requested handle, and its data is taken one cycle after `idx_rd_en`. Each index word is the byte length in its upper LEN_W bits and the byte offset in its lower DAT_AW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Decoded request present |
| req_obj_len | input | 18 | Request object length in dwords |
| req_handle | input | 16 | Requested entry handle |
| entry_count | input | 16 | Number of stored table entries |
| idx_rd_en | output | 1 | Index RAM read enable |
| idx_addr | output | IDX_AW | Index RAM address |
| idx_rdata | input | LEN_W+DAT_AW | Index RAM data {length, offset}, one-cycle latency |
| dat_rd_en | output | 1 | Data RAM read enable |
| dat_addr | output | DAT_AW | Data RAM byte address |
| dat_rdata | input | 8 | Data RAM byte, one-cycle latency |
| mbox_we | output | 1 | Mailbox write strobe |
| mbox_addr | output | MBOX_AW | Mailbox dword index |
| mbox_wdata | output | 32 | Mailbox write data |
| busy | output | 1 | Response in progress |
| bad_handle | output | 1 | One-cycle pulse on an out-of-range handle |

## Verification
On every cycle, the assertions check the following:
- Mailbox writes and data RAM reads occur only while `busy` is high.
- The mailbox addresses of a response are dense and ascending.
- The constant fields of dwords 0, 1 and 2 are correct.
- A short request never raises `busy`.
- An error pulse never coincides with a busy response.

The actual payload cannot be seen by an assertion and is left to the bench scenarios. That covers the length arithmetic, the chained next handle including the end marker, the byte placement and zero padding of the last dword, and the fact that requests overlapping a busy response are dropped.

// File: rtl/trd_pkg.sv
package trd_pkg;
  localparam logic [15:0] VENDOR_ID    = 16'h1E98;
  localparam logic [7:0]  OBJ_TYPE     = 8'd2;
  localparam logic [7:0]  RSP_CODE     = 8'd0;
  localparam logic [7:0]  TABLE_KIND   = 8'd0;
  localparam logic [15:0] END_HANDLE   = 16'hFFFF;
  localparam int          RSP_HDR_DW   = 3;
  localparam int          REQ_MIN_DW   = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_IDX, S_IWAIT, S_HDR, S_DATA
  } trd_state_e;

  function automatic logic [31:0] hdr_dword0();
    return {8'h00, OBJ_TYPE, VENDOR_ID};
  endfunction

  // header is 12 bytes; total rounded up to dwords
  function automatic logic [17:0] rsp_len_dw(input logic [31:0] nbytes);
    logic [31:0] t;
    t = (nbytes + 32'd15) >> 2;
    return t[17:0];
  endfunction

  function automatic logic [15:0] chain_next(input logic [15:0] h,
                                             input logic [15:0] cnt);
    if ((32'(h) + 32'd1) >= 32'(cnt)) return END_HANDLE;
    return h + 16'd1;
  endfunction
endpackage

// File: rtl/trd_hdr_gen.sv
module trd_hdr_gen
  import trd_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic [1:0]       sel,
  input  logic [LEN_W-1:0] nbytes,
  input  logic [15:0]      nxt,
  output logic [31:0]      dword
);
  always_comb begin
    case (sel)
      2'd0:    dword = hdr_dword0();
      2'd1:    dword = {14'h0, rsp_len_dw(32'(nbytes))};
      default: dword = {nxt, TABLE_KIND, RSP_CODE};
    endcase
  end
endmodule

// File: rtl/trd_byte_reader.sv
module trd_byte_reader #(
  parameter int DAT_AW  = 10,
  parameter int LEN_W   = 10,
  parameter int MBOX_AW = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DAT_AW-1:0]  base,
  input  logic [LEN_W-1:0]   nbytes,
  output logic               rd_en,
  output logic [DAT_AW-1:0]  rd_addr,
  input  logic [7:0]         rd_data,
  output logic               word_we,
  output logic               word_last,
  output logic [MBOX_AW-1:0] word_idx,
  output logic [31:0]        word_data
);
  logic             active;
  logic             pend;
  logic [LEN_W-1:0] rd_cnt;
  logic [LEN_W-1:0] cap_cnt;
  logic [31:0]      acc;
  logic [1:0]       lane;
  logic             issue;
  logic [31:0]      merged;

  assign issue     = active && (rd_cnt < nbytes);
  assign rd_en     = issue;
  assign rd_addr   = base + DAT_AW'(rd_cnt);
  assign lane      = cap_cnt[1:0];
  assign merged    = acc | ({24'h0, rd_data} << {lane, 3'b000});
  assign word_last = pend && (cap_cnt == nbytes - 1'b1);
  assign word_we   = pend && ((lane == 2'd3) || word_last);
  assign word_data = merged;
  assign word_idx  = MBOX_AW'(cap_cnt >> 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      pend    <= 1'b0;
      rd_cnt  <= '0;
      cap_cnt <= '0;
      acc     <= '0;
    end else if (start) begin
      active  <= 1'b1;
      pend    <= 1'b0;
      rd_cnt  <= '0;
      cap_cnt <= '0;
      acc     <= '0;
    end else begin
      pend <= issue;
      if (issue) rd_cnt <= rd_cnt + 1'b1;
      if (pend) begin
        cap_cnt <= cap_cnt + 1'b1;
        acc     <= word_we ? 32'h0 : merged;
        if (word_last) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/table_read_responder.sv
module table_read_responder
  import trd_pkg::*;
#(
  parameter int IDX_AW  = 4,
  parameter int DAT_AW  = 10,
  parameter int LEN_W   = 10,
  parameter int MBOX_AW = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [17:0]             req_obj_len,
  input  logic [15:0]             req_handle,
  input  logic [15:0]             entry_count,
  output logic                    idx_rd_en,
  output logic [IDX_AW-1:0]       idx_addr,
  input  logic [LEN_W+DAT_AW-1:0] idx_rdata,
  output logic                    dat_rd_en,
  output logic [DAT_AW-1:0]       dat_addr,
  input  logic [7:0]              dat_rdata,
  output logic                    mbox_we,
  output logic [MBOX_AW-1:0]      mbox_addr,
  output logic [31:0]             mbox_wdata,
  output logic                    busy,
  output logic                    bad_handle
);
  trd_state_e        state;
  logic [IDX_AW-1:0] handle_q;
  logic [15:0]       nxt_q;
  logic [LEN_W-1:0]  len_q;
  logic [DAT_AW-1:0] base_q;
  logic [1:0]        hcnt;
  logic              bad_q;

  // named internal events
  logic accept_w, short_w, range_ok_w, go_w, hdr_done_w, data_start_w;
  logic word_we, word_last;
  logic [MBOX_AW-1:0] word_idx;
  logic [31:0] word_data, hdr_dword;

  assign accept_w     = req_valid && (state == S_IDLE);
  assign short_w      = req_obj_len < 18'(REQ_MIN_DW);
  assign range_ok_w   = req_handle < entry_count;
  assign go_w         = accept_w && !short_w && range_ok_w;
  assign hdr_done_w   = (state == S_HDR) && (hcnt == 2'd2);
  assign data_start_w = hdr_done_w && (len_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      handle_q <= '0;
      nxt_q    <= '0;
      len_q    <= '0;
      base_q   <= '0;
      hcnt     <= '0;
      bad_q    <= 1'b0;
    end else begin
      bad_q <= accept_w && !short_w && !range_ok_w;
      case (state)
        S_IDLE: if (go_w) begin
          handle_q <= req_handle[IDX_AW-1:0];
          nxt_q    <= chain_next(req_handle, entry_count);
          state    <= S_IDX;
        end
        S_IDX:   state <= S_IWAIT;
        S_IWAIT: begin
          len_q  <= idx_rdata[LEN_W+DAT_AW-1:DAT_AW];
          base_q <= idx_rdata[DAT_AW-1:0];
          hcnt   <= '0;
          state  <= S_HDR;
        end
        S_HDR: begin
          hcnt <= hcnt + 1'b1;
          if (hdr_done_w) state <= (len_q == '0) ? S_IDLE : S_DATA;
        end
        S_DATA: if (word_we && word_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  trd_hdr_gen #(.LEN_W(LEN_W)) u_hdr (
    .sel(hcnt), .nbytes(len_q), .nxt(nxt_q), .dword(hdr_dword)
  );

  trd_byte_reader #(.DAT_AW(DAT_AW), .LEN_W(LEN_W), .MBOX_AW(MBOX_AW)) u_rdr (
    .clk(clk), .rst_n(rst_n), .start(data_start_w), .base(base_q),
    .nbytes(len_q), .rd_en(dat_rd_en), .rd_addr(dat_addr), .rd_data(dat_rdata),
    .word_we(word_we), .word_last(word_last), .word_idx(word_idx),
    .word_data(word_data)
  );

  assign idx_rd_en  = (state == S_IDX);
  assign idx_addr   = handle_q;
  assign mbox_we    = (state == S_HDR) || ((state == S_DATA) && word_we);
  assign mbox_addr  = (state == S_HDR) ? MBOX_AW'(hcnt)
                                       : MBOX_AW'(RSP_HDR_DW) + word_idx;
  assign mbox_wdata = (state == S_HDR) ? hdr_dword : word_data;
  assign busy       = (state != S_IDLE);
  assign bad_handle = bad_q;
endmodule

// File: rtl/trd_checker.sv
module trd_checker #(
  parameter int MBOX_AW = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mbox_we,
  input logic [MBOX_AW-1:0] mbox_addr,
  input logic [31:0]        mbox_wdata,
  input logic               busy,
  input logic               bad_handle,
  input logic               dat_rd_en,
  input logic               accept_w,
  input logic               short_w
);
  p_we_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_we |-> busy);
  p_hdr0_const_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_we && mbox_addr == '0) |-> mbox_wdata == 32'h00021E98);
  p_len_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_we && mbox_addr == MBOX_AW'(1)) |-> mbox_wdata[31:18] == '0);
  p_codes_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_we && mbox_addr == MBOX_AW'(2)) |-> mbox_wdata[15:0] == 16'h0);
  p_dense_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_we && $past(mbox_we)) |-> mbox_addr == $past(mbox_addr) + 1'b1);
  p_read_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rd_en |-> busy);
  p_short_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && short_w) |=> !busy);
  p_err_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_handle |-> !busy);
endmodule

bind table_read_responder trd_checker #(.MBOX_AW(MBOX_AW)) u_trd_chk (
  .clk(clk), .rst_n(rst_n), .mbox_we(mbox_we), .mbox_addr(mbox_addr),
  .mbox_wdata(mbox_wdata), .busy(busy), .bad_handle(bad_handle),
  .dat_rd_en(dat_rd_en), .accept_w(accept_w), .short_w(short_w)
);

// File: tb/table_read_responder_bench.sv
module table_read_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_AW = 4, DAT_AW = 10, LEN_W = 10, MBOX_AW = 9;
  localparam int NENT = 5;
  localparam int NVEC = 11;
  // vector: {obj_len[7:0], handle[15:0], count[7:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd3, 16'd0, 8'd5}, {8'd4, 16'd1, 8'd5}, {8'd3, 16'd2, 8'd5},
    {8'd3, 16'd3, 8'd5}, {8'd3, 16'd4, 8'd5}, {8'd2, 16'd0, 8'd5},
    {8'd0, 16'd1, 8'd5}, {8'd3, 16'd5, 8'd5}, {8'd3, 16'h0100, 8'd5},
    {8'd3, 16'd2, 8'd3}, {8'd3, 16'd0, 8'd1}
  };
  localparam int ENT_OFF [NENT] = '{0, 16, 40, 48, 100};
  localparam int ENT_LEN [NENT] = '{8, 5, 0, 13, 1};

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [17:0] req_obj_len = '0;
  logic [15:0] req_handle = '0, entry_count = 16'd5;
  logic idx_rd_en, dat_rd_en, mbox_we, busy, bad_handle;
  logic [IDX_AW-1:0] idx_addr;
  logic [LEN_W+DAT_AW-1:0] idx_rdata = '0;
  logic [DAT_AW-1:0] dat_addr;
  logic [7:0] dat_rdata = '0;
  logic [MBOX_AW-1:0] mbox_addr;
  logic [31:0] mbox_wdata;

  int checks = 0, errors = 0, wtotal = 0;
  logic [31:0] mb [0:511];

  always #(CLK_PERIOD/2) clk = ~clk;

  table_read_responder #(.IDX_AW(IDX_AW), .DAT_AW(DAT_AW), .LEN_W(LEN_W),
    .MBOX_AW(MBOX_AW)) u_table_read_responder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_obj_len(req_obj_len),
    .req_handle(req_handle), .entry_count(entry_count), .idx_rd_en(idx_rd_en),
    .idx_addr(idx_addr), .idx_rdata(idx_rdata), .dat_rd_en(dat_rd_en),
    .dat_addr(dat_addr), .dat_rdata(dat_rdata), .mbox_we(mbox_we),
    .mbox_addr(mbox_addr), .mbox_wdata(mbox_wdata), .busy(busy),
    .bad_handle(bad_handle));

  function automatic logic [7:0] dbyte(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  // memory models, one-cycle latency (R10)
  always @(posedge clk) begin
    if (idx_rd_en)
      idx_rdata <= (int'(idx_addr) < NENT)
        ? {LEN_W'(ENT_LEN[idx_addr]), DAT_AW'(ENT_OFF[idx_addr])} : '0;
    if (dat_rd_en) dat_rdata <= dbyte(int'(dat_addr));
    if (mbox_we) begin
      mb[mbox_addr] <= mbox_wdata;
      wtotal <= wtotal + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    check(n < 2000, "R8 busy timeout", 32'(n), 32'd0);
  endtask

  // checks a complete response for entry h with given count
  task automatic check_rsp(input int h, input int cnt, input int w0);
    int len, ndw;
    logic [31:0] exp;
    len = ENT_LEN[h];
    ndw = 3 + (len + 3) / 4;
    check(wtotal - w0 == ndw, (len == 0) ? "R9 write count" : "R6 write count",
          32'(wtotal - w0), 32'(ndw));
    check(mb[0] == 32'h00021E98, "R3 dword0", mb[0], 32'h00021E98);
    check(mb[1] == 32'(ndw), "R4 dword1 length", mb[1], 32'(ndw));
    exp = {((h == cnt - 1) ? 16'hFFFF : 16'(h + 1)), 16'h0000};
    check(mb[2] == exp, "R5 dword2 next handle", mb[2], exp);
    for (int d = 0; d < (len + 3) / 4; d++) begin
      exp = '0;
      for (int b = 0; b < 4; b++)
        if (d * 4 + b < len) exp[8*b +: 8] = dbyte(ENT_OFF[h] + d * 4 + b);
      check(mb[3 + d] == exp, (d * 4 + 4 > len) ? "R7 padded last dword" :
            "R6 data dword", mb[3 + d], exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w0;
    bit exp_rsp, exp_err, saw_err, saw_busy, err_after;
    repeat (3) @(negedge clk);
    check(!busy && !mbox_we && !bad_handle, "R8 reset state",
          {29'h0, busy, mbox_we, bad_handle}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      int obj, h, cnt;
      obj = int'(VEC[v][31:24]);
      h   = int'(VEC[v][23:8]);
      cnt = int'(VEC[v][7:0]);
      exp_rsp = (obj >= 3) && (h < cnt);
      exp_err = (obj >= 3) && (h >= cnt);
      w0 = wtotal;
      req_valid = 1; req_obj_len = 18'(obj); req_handle = 16'(h);
      entry_count = 16'(cnt);
      @(negedge clk);
      req_valid = 0;
      saw_busy = busy; saw_err = bad_handle;
      @(negedge clk);
      err_after = bad_handle;
      wait_idle();
      repeat (2) @(negedge clk);
      if (exp_rsp) begin
        check(saw_busy, "R8 busy after accept", 32'(saw_busy), 32'd1);
        check(!saw_err, "R10 no error on valid handle", 32'(saw_err), 32'd0);
        check_rsp(h, cnt, w0);
      end else if (exp_err) begin
        check(saw_err && !err_after, "R2 one-cycle error pulse",
              {30'h0, saw_err, err_after}, 32'h2);
        check(wtotal == w0 && !saw_busy, "R2 discarded", 32'(wtotal - w0), 32'd0);
      end else begin
        check(!saw_err && !saw_busy, "R1 short no busy no error",
              {30'h0, saw_busy, saw_err}, 32'h0);
        check(wtotal == w0, "R1 short no writes", 32'(wtotal - w0), 32'd0);
      end
    end

    // R8: a request arriving while busy is ignored
    entry_count = 16'd5;
    w0 = wtotal;
    req_valid = 1; req_obj_len = 18'd3; req_handle = 16'd3;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    req_valid = 1; req_handle = 16'd0;
    @(negedge clk);
    req_valid = 0;
    wait_idle();
    repeat (3) @(negedge clk);
    check(!busy, "R8 stays idle after ignored request", 32'(busy), 32'd0);
    check_rsp(3, 5, w0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule